// File: doc/BRIEF.md
# Page-mode mask ROM read controller

This block sits between a host and an external asynchronous mask ROM that can be read either as 16-bit words or as 32-bit double words. The host pulses `req` for one cycle with an address and a width bit. The controller then drives the ROM address lines, the select and output-enable strobes and the width-select line. It counts clock cycles until the ROM data is valid, captures it, and returns it with a one-cycle `valid` pulse. In 16-bit mode the returned value is zero-extended.

One ROM pin has two uses. In 16-bit mode it is the lowest word-address bit and the controller drives it. In 32-bit mode it is the top data bit and the controller only reads it. The pin appears as separate out, enable and in signals.

The controller keeps the chip selected between requests. A following read of the same mode whose address differs from the last one only in the in-page bits therefore takes the short page wait instead of the full random wait. After a run of idle cycles the chip is released. Any release is followed by a float turnaround before the chip is reselected or the controller drives the shared pin.

Top module: `mrom_page_reader`

## Requirements
- R1: While reset is held, and after it, `rom_ce_n` and `rom_oe_n` are 1 and `busy` and `valid` are 0 until a request arrives.
- R2: 16-bit mode (`wide`=0) drives `rom_w`=0, puts `addr[19:1]` on `rom_addr` and `addr[0]` on `rom_lsb_o` with `rom_lsb_oe`=1. It returns `{16'h0, rom_d[15:0]}` and ignores `rom_d[30:16]` and `rom_lsb_i`.
- R3: 32-bit mode (`wide`=1) drives `rom_w`=1, puts `addr[18:0]` on `rom_addr` with `rom_lsb_oe`=0, and ignores `addr[19]`. It returns `{rom_lsb_i, rom_d[30:0]}`.
- R4: A random access takes TR = ceil(max(120, 50) ns / CLK_NS) cycles, with `valid` rising TR cycles after the `req` edge. A random access is the first access after the chip is selected, or any read whose bits above the page field differ from the last read.
- R5: A page hit takes TP = ceil(50 ns / CLK_NS) cycles. A page hit needs three things: the chip is still selected, the mode is unchanged, and only the page field differs (`addr[2:0]` in 16-bit mode, `addr[1:0]` in 32-bit mode).
- R6: `valid` is high for exactly one cycle. `busy` is high from the cycle after `req` until `valid`, and it is low in the `valid` cycle.
- R7: After a read the chip stays selected. With no request for IDLE_CYC cycles after `valid`, `rom_ce_n` and `rom_oe_n` rise on the IDLE_CYC-th edge, and the next read is a random access.
- R8: After `rom_ce_n` rises, it stays high for at least TF = ceil(40 ns / CLK_NS) cycles. The controller does not drive the shared pin within 40 ns of releasing a 32-bit selection. A mode change while selected first releases the chip, and its latency is TF + TR cycles.
- R9: Data is captured no sooner than 120 ns after select or after a change of the upper address bits or width, and no sooner than 50 ns after a change of the page address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | One-cycle read request |
| addr | input | 20 | Word address (bit 19 unused in 32-bit mode) |
| wide | input | 1 | 1 selects 32-bit reads, 0 selects 16-bit reads |
| busy | output | 1 | An access or turnaround is in progress |
| valid | output | 1 | One-cycle read data strobe |
| rdata | output | 32 | Read data |
| rom_addr | output | 19 | ROM address lines |
| rom_lsb_o | output | 1 | Shared pin value in 16-bit mode (address LSB) |
| rom_lsb_oe | output | 1 | Shared pin drive enable |
| rom_lsb_i | input | 1 | Shared pin as seen from the ROM (data bit 31) |
| rom_d | input | 31 | ROM data lines 0 to 30 |
| rom_ce_n | output | 1 | ROM chip select, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_w | output | 1 | ROM width select, 1 for 32-bit |

## Verification
The assertions assume that `req` arrives only while `busy` is low, and that `addr` and `wide` are meaningful only in the cycle of `req`. The stimulus issues each request at a falling edge, drops it after the next rising edge, and always waits for `valid` or for `busy` to fall before the next one. The ROM model returns a fixed pattern computed from the address and drives junk on the lines that the current mode leaves floating. Separate bench monitors measure the real times between strobe and address changes and the capture edge.

// File: rtl/mrom_page_reader.sv
module mrom_page_reader #(
  parameter int CLK_NS     = 10,
  parameter int T_RAND_NS  = 120,
  parameter int T_PAGE_NS  = 50,
  parameter int T_OE_NS    = 50,
  parameter int T_FLOAT_NS = 40,
  parameter int IDLE_CYC   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [19:0] addr,
  input  logic        wide,
  output logic        busy,
  output logic        valid,
  output logic [31:0] rdata,
  output logic [18:0] rom_addr,
  output logic        rom_lsb_o,
  output logic        rom_lsb_oe,
  input  logic        rom_lsb_i,
  input  logic [30:0] rom_d,
  output logic        rom_ce_n,
  output logic        rom_oe_n,
  output logic        rom_w
);
  localparam int TRA = (T_RAND_NS + CLK_NS - 1) / CLK_NS;
  localparam int TOE = (T_OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int TP0 = (T_PAGE_NS + CLK_NS - 1) / CLK_NS;
  localparam int TF0 = (T_FLOAT_NS + CLK_NS - 1) / CLK_NS;
  localparam int TR  = (TRA > TOE) ? ((TRA < 1) ? 1 : TRA) : ((TOE < 1) ? 1 : TOE);
  localparam int TP  = (TP0 < 1) ? 1 : TP0;
  localparam int TF  = (TF0 < 1) ? 1 : TF0;
  localparam int CMX = (TR > TF) ? TR : TF;
  localparam int CW  = $clog2(CMX + 1) + 1;
  localparam int IW  = $clog2(IDLE_CYC + 1) + 1;
  localparam logic [CW-1:0] TR_L = CW'(TR - 1);
  localparam logic [CW-1:0] TP_L = CW'(TP - 1);
  localparam logic [CW-1:0] TF_L = CW'(TF - 1);

  typedef enum logic [1:0] {S_OFF, S_WAIT, S_HOLD, S_FLOAT} st_t;

  st_t           st;
  logic          sel, mode_q, pg_vld, pend, p_w, valid_q;
  logic [19:0]   a_q, p_a;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idle;
  logic [31:0]   rdata_q;
  logic          hit;

  assign hit = pg_vld && (wide == mode_q) &&
               (wide ? (addr[18:2] == a_q[18:2]) : (addr[19:3] == a_q[19:3]));

  assign rom_addr   = mode_q ? a_q[18:0] : a_q[19:1];
  assign rom_lsb_o  = a_q[0];
  assign rom_lsb_oe = ~mode_q;
  assign rom_w      = mode_q;
  assign rom_ce_n   = ~sel;
  assign rom_oe_n   = ~sel;
  assign busy       = (st == S_WAIT) || (st == S_FLOAT);
  assign valid      = valid_q;
  assign rdata      = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF;
      sel <= 1'b0;
      mode_q <= 1'b0;
      pg_vld <= 1'b0;
      pend <= 1'b0;
      p_w <= 1'b0;
      a_q <= '0;
      p_a <= '0;
      cnt <= '0;
      idle <= '0;
      valid_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      valid_q <= 1'b0;
      case (st)
        S_OFF: if (req) begin
          a_q <= addr;
          mode_q <= wide;
          sel <= 1'b1;
          pg_vld <= 1'b1;
          cnt <= TR_L;
          st <= S_WAIT;
        end
        S_WAIT: if (cnt == '0) begin
          valid_q <= 1'b1;
          rdata_q <= mode_q ? {rom_lsb_i, rom_d} : {16'h0, rom_d[15:0]};
          idle <= '0;
          st <= S_HOLD;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_HOLD: if (req) begin
          if (wide != mode_q) begin
            sel <= 1'b0;
            pg_vld <= 1'b0;
            pend <= 1'b1;
            p_a <= addr;
            p_w <= wide;
            cnt <= TF_L;
            st <= S_FLOAT;
          end else begin
            a_q <= addr;
            cnt <= hit ? TP_L : TR_L;
            pg_vld <= 1'b1;
            st <= S_WAIT;
          end
        end else if (idle == IW'(IDLE_CYC - 1)) begin
          sel <= 1'b0;
          pg_vld <= 1'b0;
          cnt <= TF_L;
          st <= S_FLOAT;
        end else begin
          idle <= idle + 1'b1;
        end
        S_FLOAT: if (cnt == '0) begin
          if (pend) begin
            pend <= 1'b0;
            a_q <= p_a;
            mode_q <= p_w;
            sel <= 1'b1;
            pg_vld <= 1'b1;
            cnt <= TR_L;
            st <= S_WAIT;
          end else begin
            st <= S_OFF;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_OFF;
      endcase
    end
  end

  logic [CW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= CW'(TF);
    else if (!rom_ce_n)             gap_q <= '0;
    else if (gap_q < CW'(TF))       gap_q <= gap_q + 1'b1;
  end

  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r6_not_busy_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);

  a_r8_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_ce_n) |-> (gap_q >= CW'(TF)));

  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_w));

  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_addr));
endmodule

// File: tb/mrom_page_reader_test.sv
`timescale 1ns/1ps
module mrom_page_reader_test;
  localparam int CLK_NS = 20;
  localparam int IDLE   = 8;
  localparam int TR = 6;
  localparam int TP = 3;
  localparam int TF = 2;

  logic        clk = 0, rst_n = 0, req = 0, wide = 0;
  logic [19:0] addr = '0;
  logic        busy, valid, rom_lsb_o, rom_lsb_oe, rom_lsb_i, rom_ce_n, rom_oe_n, rom_w;
  logic [31:0] rdata;
  logic [18:0] rom_addr;
  logic [30:0] rom_d;

  int total = 0, bad = 0;
  int m_total = 0, m_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  mrom_page_reader #(.CLK_NS(CLK_NS), .IDLE_CYC(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wide(wide),
    .busy(busy), .valid(valid), .rdata(rdata), .rom_addr(rom_addr),
    .rom_lsb_o(rom_lsb_o), .rom_lsb_oe(rom_lsb_oe), .rom_lsb_i(rom_lsb_i),
    .rom_d(rom_d), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_w(rom_w));

  function automatic logic [15:0] w16(input logic [19:0] a);
    logic [15:0] m;
    m = a[15:0] * 16'h3B5D;
    return m ^ {a[19:16], a[19:16], 8'h5A};
  endfunction

  function automatic logic [31:0] dw(input logic [18:0] a);
    return {w16({a, 1'b1}), w16({a, 1'b0})};
  endfunction

  logic rsel;
  assign rsel = !rom_ce_n && !rom_oe_n;
  always_comb begin
    if (!rsel) begin
      rom_d = 31'h2AAA_AAAA;
      rom_lsb_i = 1'b1;
    end else if (rom_w) begin
      rom_d = dw(rom_addr)[30:0];
      rom_lsb_i = dw(rom_addr)[31];
    end else begin
      rom_d = {15'h6D5B, w16({rom_addr, rom_lsb_o})};
      rom_lsb_i = 1'b1;
    end
  end

  realtime t_rand = 0, t_page = 0, t_sel = 0, t_off = -1000, t_rel32 = -1000;
  always @(rom_addr[18:2] or rom_w) t_rand = $realtime;
  always @(rom_addr[1:0] or rom_lsb_o) t_page = $realtime;
  always @(negedge rom_ce_n) t_sel = $realtime;
  always @(posedge rom_ce_n) begin
    t_off = $realtime;
    if (rom_w) t_rel32 = $realtime;
  end

  logic prev_ce_n = 1'b1;
  always @(negedge clk) begin
    realtime cap;
    if (rst_n) begin
      if (prev_ce_n && !rom_ce_n) begin
        m_total++;
        if (t_sel - t_off < 40.0) begin
          m_bad++;
          $display("FAIL R8 reselect gap act=%0t exp>=40", t_sel - t_off);
        end
      end
      if (rom_lsb_oe && ($realtime - t_rel32 < 40.0)) begin
        m_bad++;
        $display("FAIL R8 shared pin driven act=%0t after release exp>=40", $realtime - t_rel32);
      end
      if (valid) begin
        cap = $realtime - CLK_NS/2;
        m_total++;
        if (cap - t_rand < 120.0 || cap - t_sel < 120.0 || cap - t_page < 50.0) begin
          m_bad++;
          $display("FAIL R9 capture too early act=%0t/%0t/%0t exp>=120/120/50",
                   cap - t_rand, cap - t_sel, cap - t_page);
        end
      end
    end
    prev_ce_n = rom_ce_n;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic do_read(input logic [19:0] a, input bit wd, input int exp_lat, input string rq);
    int k;
    logic [31:0] ex;
    req = 1'b1; addr = a; wide = wd;
    @(posedge clk);
    #1 req = 1'b0;
    @(negedge clk);
    k = 1;
    chk(busy == 1'b1, "R6 busy after req", 32'(busy), 32'd1);
    while (!valid && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(k - 1 == exp_lat, {rq, " latency"}, 32'(k - 1), 32'(exp_lat));
    chk(busy == 1'b0, "R6 busy low on valid", 32'(busy), 32'd0);
    if (wd) begin
      ex = dw(a[18:0]);
      chk(rdata == ex, "R3 data", rdata, ex);
      chk(rom_w == 1'b1, "R3 width line", 32'(rom_w), 32'd1);
      chk(rom_addr == a[18:0], "R3 address", 32'(rom_addr), 32'(a[18:0]));
      chk(rom_lsb_oe == 1'b0, "R3 pin released", 32'(rom_lsb_oe), 32'd0);
    end else begin
      ex = {16'h0, w16(a)};
      chk(rdata == ex, "R2 data", rdata, ex);
      chk(rom_w == 1'b0, "R2 width line", 32'(rom_w), 32'd0);
      chk(rom_addr == a[19:1], "R2 address", 32'(rom_addr), 32'(a[19:1]));
      chk(rom_lsb_oe && rom_lsb_o == a[0], "R2 pin lsb", {30'd0, rom_lsb_oe, rom_lsb_o}, {30'd0, 1'b1, a[0]});
    end
    @(negedge clk);
    chk(valid == 1'b0, "R6 valid one cycle", 32'(valid), 32'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(rom_ce_n && rom_oe_n, "R1 strobes idle in reset", {30'd0, rom_ce_n, rom_oe_n}, 32'd3);
    chk(!busy && !valid, "R1 busy/valid in reset", {30'd0, busy, valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rom_ce_n && !busy, "R1 idle after reset", {30'd0, rom_ce_n, busy}, 32'd2);
  endtask

  task automatic t_word_mode;
    do_read(20'h12345, 1'b0, TR, "R4 first select");
    do_read(20'h12342, 1'b0, TP, "R5 page hit");
    do_read(20'h12347, 1'b0, TP, "R5 page edge");
    do_read(20'h12348, 1'b0, TR, "R4 next page");
    do_read(20'h92348, 1'b0, TR, "R4 bit19 change");
  endtask

  task automatic t_mode_switch_up;
    do_read(20'h0ABCD, 1'b1, TF + TR, "R8 mode change");
  endtask

  task automatic t_dword_mode;
    do_read(20'h0ABCE, 1'b1, TP, "R5 page hit 32");
    do_read(20'h8ABCF, 1'b1, TP, "R3 bit19 ignored hit");
    do_read(20'h0ABD0, 1'b1, TR, "R4 next page 32");
  endtask

  task automatic t_idle_release;
    repeat (IDLE - 2) @(negedge clk);
    chk(rom_ce_n == 1'b0, "R7 still selected", 32'(rom_ce_n), 32'd0);
    @(negedge clk);
    chk(rom_ce_n && rom_oe_n, "R7 released at timeout", {30'd0, rom_ce_n, rom_oe_n}, 32'd3);
    chk(busy == 1'b1, "R8 busy during float", 32'(busy), 32'd1);
    repeat (TF) @(negedge clk);
    chk(busy == 1'b0, "R8 float ends", 32'(busy), 32'd0);
    do_read(20'h0ABD1, 1'b1, TR, "R7 random after release");
  endtask

  task automatic t_mode_switch_down;
    do_read(20'h00003, 1'b0, TF + TR, "R8 mode change down");
    do_read(20'h00000, 1'b0, TP, "R5 page hit after switch");
  endtask

  initial begin
    t_reset();
    t_word_mode();
    t_mode_switch_up();
    t_dword_mode();
    t_idle_release();
    t_mode_switch_down();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total + m_total, bad + m_bad);
    $finish;
  end

  initial begin
    #(200000 * CLK_NS);
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total + m_total + 1, bad + m_bad + 1);
    $finish;
  end
endmodule